// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

This block is a small 16-bit processor that runs one instruction at a time through a short fixed sequence of states. It has eight general registers and a three-flag condition register. Code and data share one word-addressed memory, which it reaches through a simple synchronous port. Arithmetic is limited to add, bitwise and, and bitwise not. Control flow covers conditional branch, register jump, PC-relative call and return through register 7. Memory access comes in three forms: PC-relative, base plus offset, and double-indirect through a pointer word. There is also a load-effective-address operation.

A trap instruction connects the core to a byte-wide console. One trap code waits for an input byte and puts it in register 0. Another offers the low byte of register 0 as output. A third stops the core for good. Each console exchange uses a valid/ready handshake, and the core stalls in place until the exchange completes.

The core is meant to sit beside a single-port memory with one cycle of read latency. A byte stream source and sink connect to the console pins.

Top module: `mc16_core`

## Requirements
- R1: While reset is asserted and after it is released, the first memory request is a read of address 0x3000. `halted` and `illegal_seen` are low. The condition flags reset to "zero".
- R2: The operation is selected by bits 15:12. Add is 1, and is 5, not is 9. Bits 11:9 name the destination and bits 8:6 the first source. When bit 5 is set, the second operand is bits 4:0 sign-extended; when it is clear, the second operand is the register in bits 2:0. Add, and, not, load-effective-address and every load set exactly one flag: negative, zero or positive.
- R3: Branch (opcode 0) is taken when its mask has a bit set that matches a flag. Mask bit 11 matches negative, bit 10 zero and bit 9 positive. A taken branch loads PC with the incremented PC plus the sign-extended bits 8:0.
- R4: Load (2), store (3) and load-effective-address (14) use the incremented PC plus the sign-extended bits 8:0 as their address. A store writes the register named in bits 11:9.
- R5: Base load (6) and base store (7) address memory at the register in bits 8:6 plus the sign-extended bits 5:0. The offset may be negative.
- R6: Indirect load (10) and indirect store (11) first read a pointer word at the PC-relative address. They then read or write memory at that pointer.
- R7: Call (4) saves the incremented PC in register 7 and jumps PC-relative. Jump (12) loads PC from the register in bits 8:6, so 0xC1C0 returns through register 7.
- R8: Trap with bits 7:0 = 0x20 raises `con_in_ready`. It stalls, with no memory requests, until `con_in_valid` is seen. The byte then goes to register 0 zero-extended, and the flags are left unchanged.
- R9: Trap 0x21 raises `con_out_valid` with the low byte of register 0 on `con_out_data`. Both hold steady until `con_out_ready` is seen.
- R10: Trap 0x25 raises `halted`. It stays high, and no further memory requests are made, until reset.
- R11: Opcodes 8 and 13 act as no-operations, and execution continues with the next word. They set `illegal_seen`, which stays set until reset.
- R12: Memory read data is taken in the cycle after the request. A write happens only together with a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable, valid with mem_req |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| con_in_valid | input | 1 | Console input byte available |
| con_in_ready | output | 1 | Core waiting for an input byte |
| con_in_data | input | 8 | Console input byte |
| con_out_valid | output | 1 | Console output byte offered |
| con_out_ready | input | 1 | Sink accepts the output byte |
| con_out_data | output | 8 | Console output byte |
| halted | output | 1 | Core stopped by the halt trap |
| illegal_seen | output | 1 | Sticky flag for opcodes 8 and 13 |

## Verification
A wrong register value, flag or PC stays hidden inside the core until something reaches a store or a console byte. For that reason the test program writes every intermediate result to a results area, and the bench compares that area after the halt. A wrong flag or branch decision shows up as a skipped or extra store, as a missing console exchange, or as a misplaced `illegal_seen` flag, a few instructions later. Sequencer faults show up at once on the memory and console pins. Examples are a request made while stalled or halted, output data that moves before it is accepted, and a first fetch at the wrong address.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int WORD_W  = 16;
  localparam int REG_CNT = 8;
  localparam int REG_AW  = $clog2(REG_CNT);
  localparam int OPC_W   = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_BR   = 4'd0,  OP_ADD  = 4'd1,  OP_LD   = 4'd2,  OP_ST   = 4'd3,
    OP_JSR  = 4'd4,  OP_AND  = 4'd5,  OP_LDR  = 4'd6,  OP_STR  = 4'd7,
    OP_RSV8 = 4'd8,  OP_NOT  = 4'd9,  OP_LDI  = 4'd10, OP_STI  = 4'd11,
    OP_JMP  = 4'd12, OP_RSV13 = 4'd13, OP_LEA = 4'd14, OP_TRAP = 4'd15
  } op_t;

  typedef enum logic [2:0] {
    S_FETCH, S_FWAIT, S_EXEC, S_MEM, S_MWAIT, S_CIN, S_COUT, S_HALT
  } state_t;

  localparam logic [7:0] VEC_GETC = 8'h20;
  localparam logic [7:0] VEC_PUTC = 8'h21;
  localparam logic [7:0] VEC_STOP = 8'h25;

  function automatic logic [WORD_W-1:0] sx9(input logic [8:0] v);
    return {{(WORD_W-9){v[8]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] sx6(input logic [5:0] v);
    return {{(WORD_W-6){v[5]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] sx5(input logic [4:0] v);
    return {{(WORD_W-5){v[4]}}, v};
  endfunction
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile import mc16_pkg::*; #(
  parameter int W  = WORD_W,
  parameter int N  = REG_CNT,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && wa == AW'(g)) regs[g] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu import mc16_pkg::*; #(
  parameter int W = WORD_W
) (
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_NOT:  y = ~a;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mc16_agu.sv
module mc16_agu import mc16_pkg::*; #(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] pc_next,
  input  logic [W-1:0] base,
  input  logic [8:0]   off,
  output logic [W-1:0] pc_rel,
  output logic [W-1:0] base_rel
);
  assign pc_rel   = pc_next + sx9(off);
  assign base_rel = base + sx6(off[5:0]);
endmodule

// File: rtl/mc16_flags.sv
module mc16_flags import mc16_pkg::*; #(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] val,
  output logic [2:0]   nzp
);
  always_ff @(posedge clk) begin
    if (rst) nzp <= 3'b010;
    else if (upd) begin
      if (val[W-1])      nzp <= 3'b100;
      else if (val == '0) nzp <= 3'b010;
      else                nzp <= 3'b001;
    end
  end

  // R2
  flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(nzp));

  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(nzp));
endmodule

// File: rtl/mc16_core.sv
module mc16_core import mc16_pkg::*; #(
  parameter logic [WORD_W-1:0] RESET_PC = 16'h3000,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              con_in_valid,
  output logic              con_in_ready,
  input  logic [CHAR_W-1:0] con_in_data,
  output logic              con_out_valid,
  input  logic              con_out_ready,
  output logic [CHAR_W-1:0] con_out_data,
  output logic              halted,
  output logic              illegal_seen
);
  localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(REG_CNT - 1);

  state_t            st_q;
  logic [WORD_W-1:0] pc_q, ir_q, maddr_q;
  logic              ind_q, halt_q, ill_q;

  op_t               opc;
  logic [REG_AW-1:0] dr, sr1, rb_sel;
  logic [WORD_W-1:0] ra, rb, alu_b, alu_y, pc_rel, base_rel;
  logic              is_load, is_store, is_ind;
  logic              rf_we, cc_upd;
  logic [REG_AW-1:0] rf_wa;
  logic [WORD_W-1:0] rf_wd;
  logic [2:0]        nzp;

  assign opc      = op_t'(ir_q[15:12]);
  assign dr       = ir_q[11:9];
  assign sr1      = ir_q[8:6];
  assign is_load  = (opc == OP_LD) || (opc == OP_LDR) || (opc == OP_LDI);
  assign is_store = (opc == OP_ST) || (opc == OP_STR) || (opc == OP_STI);
  assign is_ind   = (opc == OP_LDI) || (opc == OP_STI);

  always_comb begin
    if (opc == OP_ADD || opc == OP_AND) rb_sel = ir_q[2:0];
    else if (opc == OP_TRAP)            rb_sel = '0;
    else                                rb_sel = dr;
  end

  mc16_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra_a(sr1), .rd_a(ra), .ra_b(rb_sel), .rd_b(rb)
  );

  assign alu_b = ir_q[5] ? sx5(ir_q[4:0]) : rb;

  mc16_alu #(.W(WORD_W)) u_alu (.op(opc), .a(ra), .b(alu_b), .y(alu_y));

  mc16_agu #(.W(WORD_W)) u_agu (
    .pc_next(pc_q), .base(ra), .off(ir_q[8:0]),
    .pc_rel(pc_rel), .base_rel(base_rel)
  );

  mc16_flags #(.W(WORD_W)) u_flags (
    .clk(clk), .rst(rst), .upd(cc_upd), .val(rf_wd), .nzp(nzp)
  );

  // register write port and flag update
  always_comb begin
    rf_we  = 1'b0;
    rf_wa  = dr;
    rf_wd  = alu_y;
    cc_upd = 1'b0;
    case (st_q)
      S_EXEC: begin
        case (opc)
          OP_ADD, OP_AND, OP_NOT: begin
            rf_we  = 1'b1;
            cc_upd = 1'b1;
          end
          OP_LEA: begin
            rf_we  = 1'b1;
            rf_wd  = pc_rel;
            cc_upd = 1'b1;
          end
          OP_JSR: begin
            rf_we = 1'b1;
            rf_wa = LINK_REG;
            rf_wd = pc_q;
          end
          default: ;
        endcase
      end
      S_MWAIT: begin
        if (is_load && (!is_ind || ind_q)) begin
          rf_we  = 1'b1;
          rf_wd  = mem_rdata;
          cc_upd = 1'b1;
        end
      end
      S_CIN: begin
        if (con_in_valid) begin
          rf_we = 1'b1;
          rf_wa = '0;
          rf_wd = {{(WORD_W-CHAR_W){1'b0}}, con_in_data};
        end
      end
      default: ;
    endcase
  end

  // memory and console strobes decoded from the state register
  assign mem_req       = (st_q == S_FETCH) || (st_q == S_MEM);
  assign mem_addr      = (st_q == S_FETCH) ? pc_q : maddr_q;
  assign mem_we        = (st_q == S_MEM) && is_store && (!is_ind || ind_q);
  assign mem_wdata     = rb;
  assign con_in_ready  = (st_q == S_CIN);
  assign con_out_valid = (st_q == S_COUT);
  assign con_out_data  = rb[CHAR_W-1:0];
  assign halted        = halt_q;
  assign illegal_seen  = ill_q;

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      maddr_q <= '0;
      ind_q   <= 1'b0;
      halt_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (st_q)
        S_FETCH: begin
          pc_q <= pc_q + 1'b1;
          st_q <= S_FWAIT;
        end
        S_FWAIT: begin
          ir_q  <= mem_rdata;
          ind_q <= 1'b0;
          st_q  <= S_EXEC;
        end
        S_EXEC: begin
          st_q <= S_FETCH;
          case (opc)
            OP_BR:  if (|(dr & nzp)) pc_q <= pc_rel;
            OP_JMP: pc_q <= ra;
            OP_JSR: pc_q <= pc_rel;
            OP_LD, OP_ST, OP_LDI, OP_STI: begin
              maddr_q <= pc_rel;
              st_q    <= S_MEM;
            end
            OP_LDR, OP_STR: begin
              maddr_q <= base_rel;
              st_q    <= S_MEM;
            end
            OP_TRAP: begin
              case (ir_q[7:0])
                VEC_GETC: st_q <= S_CIN;
                VEC_PUTC: st_q <= S_COUT;
                VEC_STOP: begin
                  st_q   <= S_HALT;
                  halt_q <= 1'b1;
                end
                default: ;
              endcase
            end
            OP_RSV8, OP_RSV13: ill_q <= 1'b1;
            default: ;
          endcase
        end
        S_MEM: st_q <= mem_we ? S_FETCH : S_MWAIT;
        S_MWAIT: begin
          if (is_ind && !ind_q) begin
            maddr_q <= mem_rdata;
            ind_q   <= 1'b1;
            st_q    <= S_MEM;
          end else begin
            st_q <= S_FETCH;
          end
        end
        S_CIN:  if (con_in_valid) st_q <= S_FETCH;
        S_COUT: if (con_out_ready) st_q <= S_FETCH;
        default: st_q <= S_HALT;
      endcase
    end
  end

  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_req && !mem_we && mem_addr == RESET_PC));

  // R8
  cin_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (con_in_ready && !con_in_valid) |=> (con_in_ready && !mem_req));

  // R9
  cout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (con_out_valid && !con_out_ready) |=> (con_out_valid && $stable(con_out_data)));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req);

  // R11
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_seen |=> illegal_seen);

  // R12
  write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);
endmodule

// File: tb/mc16_core_tb.sv
module mc16_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        con_in_valid = 1'b0;
  logic        con_in_ready;
  logic [7:0]  con_in_data = '0;
  logic        con_out_valid;
  logic        con_out_ready = 1'b0;
  logic [7:0]  con_out_data;
  logic        halted, illegal_seen;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mc16_core dut_i (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .con_in_valid(con_in_valid), .con_in_ready(con_in_ready),
    .con_in_data(con_in_data),
    .con_out_valid(con_out_valid), .con_out_ready(con_out_ready),
    .con_out_data(con_out_data),
    .halted(halted), .illegal_seen(illegal_seen)
  );

  // memory model: one cycle read latency, 1024 words, address bits 9:0
  logic [15:0] ram [1024];
  logic        load_en = 1'b0;
  logic [9:0]  load_a  = '0;
  logic [15:0] load_d  = '0;

  always @(posedge clk) begin
    if (load_en) ram[load_a] <= load_d;
    else if (mem_req) begin
      if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[9:0]];
    end
  end

  // program 1: {address, word}
  localparam logic [31:0] PROG1 [42] = '{
    32'h3000_EC9F, 32'h3001_5260, 32'h3002_1265, 32'h3003_1475,
    32'h3004_1642, 32'h3005_58C1, 32'h3006_9ABF, 32'h3007_7580,
    32'h3008_7781, 32'h3009_7982, 32'h300A_7B83, 32'h300B_0801,
    32'h300C_1261, 32'h300D_0201, 32'h300E_1268, 32'h300F_7384,
    32'h3010_206F, 32'h3011_3093, 32'h3012_A26E, 32'h3013_0801,
    32'h3014_5260, 32'h3015_7386, 32'h3016_B66C, 32'h3017_65A0,
    32'h3018_7588, 32'h3019_4826, 32'h301A_0401, 32'h301B_8000,
    32'h301C_F020, 32'h301D_1021, 32'h301E_F021, 32'h301F_718A,
    32'h3020_F025, 32'h3021_738B, 32'h3040_7F89, 32'h3041_C1C0,
    32'h3080_1234, 32'h3081_3082, 32'h3082_8001, 32'h3083_30A7,
    32'h30AB_0000, 32'h30AA_0000
  };

  // expected results area: {address, value, requirement index}
  localparam logic [35:0] EXP1 [12] = '{
    36'h30A0_FFFA_2, 36'h30A1_FFFF_2, 36'h30A2_0005_2, 36'h30A3_0005_2,
    36'h30A4_0006_3, 36'h30A5_1234_4, 36'h30A6_8001_6, 36'h30A7_FFFF_6,
    36'h30A8_1234_5, 36'h30A9_301A_7, 36'h30AA_0042_8, 36'h30AB_0000_A
  };

  localparam logic [31:0] PROG2 [5] = '{
    32'h3000_0401, 32'h3001_F025, 32'h3002_D000, 32'h3003_F021,
    32'h3004_F025
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    load_en = 1'b1; load_a = a[9:0]; load_d = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic clear_ram;
    for (int i = 0; i < 1024; i++) put_word(16'(i), 16'h0000);
  endtask

  task automatic start_core;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 first request", {15'd0, mem_req}, 16'd1);
    chk("R1 first address", mem_addr, 16'h3000);
    chk("R1 halted low", {15'd0, halted}, 16'd0);
    chk("R1 illegal low", {15'd0, illegal_seen}, 16'd0);
  endtask

  task automatic wait_sig(input int which);
    for (int i = 0; i < 3000; i++) begin
      if ((which == 0 && con_in_ready) || (which == 1 && con_out_valid) ||
          (which == 2 && halted)) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int bad;
    rst = 1'b1;
    clear_ram();
    foreach (PROG1[k]) put_word(PROG1[k][31:16], PROG1[k][15:0]);
    start_core();

    // R8: input trap stalls without memory traffic
    wait_sig(0);
    chk("R8 input request", {15'd0, con_in_ready}, 16'd1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!con_in_ready || mem_req) bad++;
    end
    chk("R8 stall quiet", 16'(bad), 16'd0);
    con_in_data = 8'h41; con_in_valid = 1'b1;
    @(negedge clk);
    con_in_valid = 1'b0;
    chk("R8 ready drops", {15'd0, con_in_ready}, 16'd0);

    // R9: output byte held until accepted
    wait_sig(1);
    chk("R9 output valid", {15'd0, con_out_valid}, 16'd1);
    chk("R9 output data", {8'd0, con_out_data}, 16'h0042);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!con_out_valid || con_out_data != 8'h42 || mem_req) bad++;
    end
    chk("R9 output held", 16'(bad), 16'd0);
    con_out_ready = 1'b1;
    @(negedge clk);
    con_out_ready = 1'b0;
    chk("R9 valid drops", {15'd0, con_out_valid}, 16'd0);

    // R10: halt is sticky and quiet
    wait_sig(2);
    chk("R10 halted", {15'd0, halted}, 16'd1);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!halted || mem_req) bad++;
    end
    chk("R10 quiet after halt", 16'(bad), 16'd0);
    chk("R11 illegal opcode 8 flagged", {15'd0, illegal_seen}, 16'd1);

    // results area walk (R2 R3 R4 R5 R6 R7 R8 R10 R12)
    foreach (EXP1[k]) begin
      string tag;
      tag = $sformatf("R%0d result at %h", EXP1[k][3:0], EXP1[k][35:20]);
      chk(tag, ram[EXP1[k][29:20]], EXP1[k][19:4]);
    end

    // second run: reset flags, opcode 13, output of reset register 0
    rst = 1'b1;
    clear_ram();
    foreach (PROG2[k]) put_word(PROG2[k][31:16], PROG2[k][15:0]);
    start_core();
    wait_sig(1);
    chk("R1 zero flag at reset takes branch", {15'd0, con_out_valid}, 16'd1);
    chk("R11 opcode 13 flagged", {15'd0, illegal_seen}, 16'd1);
    chk("R9 reset register byte", {8'd0, con_out_data}, 16'h0000);
    con_out_ready = 1'b1;
    @(negedge clk);
    con_out_ready = 1'b0;
    wait_sig(2);
    chk("R10 second halt", {15'd0, halted}, 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule